// File: doc/BRIEF.md
# Block-Protocol Serial Register Slave

This block is a two-wire serial bus slave that answers at one fixed 7-bit address and gives the bus master access to a small bank of 8-bit control registers. The register contents are presented in parallel to the surrounding logic, which uses them as configuration. Each register loads its own default value when reset is applied.

The block runs on a system clock that is much faster than the serial clock. Both bus lines pass through a synchronizer and a glitch filter, and the filtered lines are then decoded into clock edges and START/STOP conditions. The slave pulls SDA low through an output enable, following the open-drain convention. It never holds SCL.

Transfers use a block framing. A write begins with the address byte 0xD2, followed by two header bytes (a command byte and a length byte). The slave acknowledges both header bytes and then discards them. The data bytes that follow fill register 0, register 1 and onward. A read begins with the address byte 0xD3. The slave first returns a fixed length byte and then the registers in ascending order, always starting from register 0.

Top module: `smb_blk_slave`

## Requirements
- R1: After reset, the register outputs read 0x42 for register 0 and 0xFF for registers 1, 2 and 3. Register i sits in `reg_q[8*i+7:8*i]`. `sda_oe` is 0.
- R2: An address byte whose upper seven bits are 1101001 (0xD2 for write, 0xD3 for read) is acknowledged by holding SDA low during the ninth clock. Any other address is not acknowledged, and the slave then ignores the bus until the next START.
- R3: In a write, the two bytes after the address are acknowledged and leave every register unchanged. Each following byte, received most-significant bit first, is stored in register 0, then register 1, and so on. Registers change only on a falling SCL edge.
- R4: Write data bytes beyond the last register are acknowledged and discarded.
- R5: In a read, the slave first sends the length value 0x09 and then registers 0, 1, ... in ascending order, most-significant bit first. The slave changes SDA only while SCL is low.
- R6: A read that goes past the last register returns 0x00.
- R7: A master NACK after a read byte ends the transfer. The slave releases SDA and drives nothing more until a START.
- R8: A START or repeated START at any point restarts address reception, releases SDA, and resets the register pointer to register 0.
- R9: A STOP releases SDA and returns the slave to idle, so that a later byte sent without a START is not acknowledged.
- R10: A pulse on SCL or SDA that is shorter than the filter length (3 system clocks by default) is ignored.
- R11: A written register takes its new value in the same system-clock cycle in which the slave starts driving the acknowledge for that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| reg_q | output | NUM_REGS*8 | Parallel register contents, register i in bits 8*i+7:8*i |

## Verification
Two things happen in the same system-clock cycle: the commit of a received data byte into the register bank, and the start of the slave's acknowledge drive for that byte. Both happen on the filtered SCL falling edge that ends the eighth bit. The bench writes a data byte and, on the falling clock edge, records the cycle in which `reg_q` changes and the cycle in which `sda_oe` rises. It then requires the two cycle numbers to be equal. A bound property makes the same check on every commit throughout the run.

// File: rtl/smb_slv_pkg.sv
package smb_slv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACK,
    PH_WR,
    PH_RD,
    PH_RDACK
  } phase_e;

  // header bytes (command, length) that precede write data
  localparam int unsigned HDR_BYTES = 2;

endpackage

// File: rtl/smb_line_filter.sv
module smb_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o,
  output logic sync_o
);
  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]       sync_q;
  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (sync_q[1] == filt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
      filt_d = sync_q[1];
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = filt_q;
  assign sync_o = sync_q[1];

endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int unsigned NUM_REGS = 4,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = 32'hFFFF_FF42,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic ce;
    assign ce = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= RST_VAL[8*g +: 8];
      end else if (ce) begin
        mem_q[g] <= wr_data;
      end
    end
    assign regs_o[8*g +: 8] = mem_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
    end
  end

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_slv_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR = 7'b1101001,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [7:0]  BCNT_VAL = 8'h09,
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_i,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam int unsigned PTR_MAX = NUM_REGS + HDR_BYTES;
  localparam int unsigned PTR_W   = $clog2(PTR_MAX + 1);

  phase_e           ph_q, ph_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             rd_q, rd_d;
  logic             oe_q, oe_d;

  logic [PTR_W-1:0] ptr_m1, wr_off, ptr_inc;
  logic             rd_in_range, wr_ok;
  logic [7:0]       tx_byte;

  // pointer decode for both directions
  assign ptr_m1      = ptr_q - 1'b1;
  assign wr_off      = ptr_q - PTR_W'(HDR_BYTES);
  assign ptr_inc     = (ptr_q == PTR_W'(PTR_MAX)) ? ptr_q : ptr_q + 1'b1;
  assign rd_in_range = (ptr_q != '0) && (ptr_m1 < PTR_W'(NUM_REGS));
  assign wr_ok       = (ptr_q >= PTR_W'(HDR_BYTES)) && (wr_off < PTR_W'(NUM_REGS));
  assign rd_idx      = ptr_m1[IDX_W-1:0];
  assign wr_idx      = wr_off[IDX_W-1:0];
  assign wr_data     = sh_q;

  always_comb begin
    if (ptr_q == '0)      tx_byte = BCNT_VAL;
    else if (rd_in_range) tx_byte = rd_data;
    else                  tx_byte = 8'h00;
  end

  always_comb begin
    ph_d  = ph_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    ptr_d = ptr_q;
    rd_d  = rd_q;
    oe_d  = oe_q;
    wr_en = 1'b0;
    if (start_det) begin
      ph_d  = PH_ADDR;
      bit_d = '0;
      ptr_d = '0;
      oe_d  = 1'b0;
    end else if (stop_det) begin
      ph_d = PH_IDLE;
      oe_d = 1'b0;
    end else begin
      case (ph_q)
        PH_ADDR, PH_WR: begin
          if (scl_rise && bit_q != 4'd8) begin
            sh_d  = {sh_q[6:0], sda_i};
            bit_d = bit_q + 1'b1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (ph_q == PH_ADDR) begin
              if (sh_q[7:1] == SLV_ADDR) begin
                rd_d  = sh_q[0];
                oe_d  = 1'b1;
                ptr_d = '0;
                ph_d  = PH_ACK;
              end else begin
                ph_d = PH_IDLE;
              end
            end else begin
              wr_en = wr_ok;
              ptr_d = ptr_inc;
              oe_d  = 1'b1;
              ph_d  = PH_ACK;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rd_q) begin
              sh_d  = tx_byte;
              oe_d  = ~tx_byte[7];
              ptr_d = ptr_inc;
              ph_d  = PH_RD;
            end else begin
              oe_d = 1'b0;
              ph_d = PH_WR;
            end
          end
        end
        PH_RD: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              oe_d = 1'b0;
              ph_d = PH_RDACK;
            end else begin
              sh_d  = {sh_q[6:0], 1'b0};
              oe_d  = ~sh_q[6];
              bit_d = bit_q + 1'b1;
            end
          end
        end
        PH_RDACK: begin
          if (scl_rise) ph_d = sda_i ? PH_IDLE : PH_ACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      bit_q <= '0;
      sh_q  <= '0;
      ptr_q <= '0;
      rd_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      ptr_q <= ptr_d;
      rd_q  <= rd_d;
      oe_q  <= oe_d;
    end
  end

  assign sda_oe = oe_q;

endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
  parameter logic [6:0]  SLV_ADDR = 7'b1101001,
  parameter int unsigned NUM_REGS = 4,
  parameter logic [7:0]  BCNT_VAL = 8'h09,
  parameter logic [NUM_REGS*8-1:0] RST_VAL = 32'hFFFF_FF42,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] reg_q
);
  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // line index 0 = SCL, 1 = SDA
  logic [1:0] line_raw, line_f, line_s;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    smb_line_filter #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk    (clk),
      .rst_n  (rst_s),
      .line_i (line_raw[g]),
      .line_o (line_f[g]),
      .sync_o (line_s[g])
    );
  end

  logic scl_rise, scl_fall, start_det, stop_det;

  smb_bus_events evt_i (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_i     (line_f[0]),
    .sda_i     (line_f[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [7:0]       rd_data, wr_data;
  logic             wr_en;

  smb_xfer_fsm #(
    .SLV_ADDR (SLV_ADDR),
    .NUM_REGS (NUM_REGS),
    .BCNT_VAL (BCNT_VAL)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_i     (line_f[1]),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  smb_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .RST_VAL  (RST_VAL)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .regs_o  (reg_q)
  );

endmodule

// File: rtl/smb_blk_slave_chk.sv
module smb_blk_slave_chk #(
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic [REG_W-1:0] reg_q
);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R3
  reg_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q) |-> $past(scl_fall));

  // R11
  commit_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_q) |-> sda_oe);

  // R5
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  // R10
  scl_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_f) |-> ($past(scl_s, 1) && $past(scl_s, 2)));

endmodule

bind smb_blk_slave smb_blk_slave_chk #(.REG_W(NUM_REGS*8)) chk_i (
  .clk       (clk),
  .rst_n     (rst_s),
  .scl_f     (line_f[0]),
  .scl_s     (line_s[0]),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .reg_q     (reg_q)
);

// File: tb/smb_blk_slave_tb.sv
module smb_blk_slave_tb_top;

  localparam int Q = 25;  // system clocks per quarter SCL bit

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m_scl = 1'b1;
  logic        m_sda = 1'b1;
  logic        sda_oe;
  logic [31:0] reg_q;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  smb_blk_slave dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (m_scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe),
    .reg_q  (reg_q)
  );

  // port monitor for the commit / acknowledge cycle (R11)
  int          cyc = 0;
  int          cyc_reg_chg = -1;
  int          cyc_oe_rise = -2;
  logic [31:0] reg_last = '0;
  logic        oe_last = 1'b0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && reg_q !== reg_last) cyc_reg_chg <= cyc;
    if (rst_n && sda_oe && !oe_last) cyc_oe_rise <= cyc;
    reg_last <= reg_q;
    oe_last  <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b0; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      wq(1);
      if (glitch) begin
        m_scl = 1'b1; @(negedge clk); m_scl = 1'b0;
      end
      m_scl = 1'b1;
      wq(1);
      if (glitch) begin
        m_sda = ~b[i]; @(negedge clk); m_sda = b[i];
      end
      wq(1);
      m_scl = 1'b0;
      wq(1);
    end
    m_sda = 1'b1;
    wq(1);
    m_scl = 1'b1;
    wq(1);
    ack = ~sda_line;
    wq(1);
    m_scl = 1'b0;
    wq(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      m_scl = 1'b1;
      wq(1);
      b[i] = sda_line;
      wq(1);
      m_scl = 1'b0;
      wq(1);
    end
    m_sda = ~give_ack;
    wq(1);
    m_scl = 1'b1;
    wq(2);
    m_scl = 1'b0;
    wq(1);
    m_sda = 1'b1;
  endtask

  // address vectors: {address byte, acknowledge expected}
  localparam logic [8:0] ADDR_TAB [0:5] = '{
    {8'hD2, 1'b1}, {8'hD3, 1'b1}, {8'hD0, 1'b0},
    {8'h52, 1'b0}, {8'hD6, 1'b0}, {8'hE3, 1'b0}
  };

  initial begin
    repeat (400000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit          ack;
    logic [7:0]  rb;
    logic [31:0] exp_r;
    logic [7:0]  rd_exp [0:6];

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 sda_oe in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    exp_r = 32'hFFFF_FF42;
    chk(reg_q == exp_r, "R1 defaults", reg_q, exp_r);
    chk(sda_oe == 1'b0, "R1 sda released", {31'd0, sda_oe}, 32'd0);

    // address matching table
    for (int v = 0; v < 6; v++) begin
      bus_start();
      send_byte(ADDR_TAB[v][8:1], 1'b0, ack);
      chk(ack == ADDR_TAB[v][0], "R2 address ack", {31'd0, ack}, {31'd0, ADDR_TAB[v][0]});
      if (ack && ADDR_TAB[v][1]) begin
        recv_byte(1'b0, rb);
        chk(rb == 8'h09, "R5 length byte", {24'd0, rb}, 32'h09);
      end else if (!ack) begin
        send_byte(8'h00, 1'b0, ack);
        chk(ack == 1'b0, "R2 silent after mismatch", {31'd0, ack}, 32'd0);
      end
      bus_stop();
    end

    // block write: header discarded, then registers 0..3
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'hA5, 1'b0, ack);
    chk(ack, "R3 command ack", {31'd0, ack}, 32'd1);
    send_byte(8'h04, 1'b0, ack);
    chk(ack, "R3 length ack", {31'd0, ack}, 32'd1);
    chk(reg_q == exp_r, "R3 header ignored", reg_q, exp_r);
    send_byte(8'h11, 1'b0, ack);
    chk(reg_q[7:0] == 8'h11, "R3 first data to reg0", reg_q, 32'h11);
    chk(cyc_reg_chg == cyc_oe_rise, "R11 commit with ack",
        cyc_reg_chg, cyc_oe_rise);
    send_byte(8'h22, 1'b0, ack);
    send_byte(8'h33, 1'b0, ack);
    send_byte(8'h44, 1'b0, ack);
    chk(ack, "R3 data ack", {31'd0, ack}, 32'd1);
    bus_stop();
    exp_r = 32'h4433_2211;
    chk(reg_q == exp_r, "R3 block write", reg_q, exp_r);

    // block read: length, registers, then past the end
    rd_exp = '{8'h09, 8'h11, 8'h22, 8'h33, 8'h44, 8'h00, 8'h00};
    bus_start();
    send_byte(8'hD3, 1'b0, ack);
    for (int k = 0; k < 7; k++) begin
      recv_byte(k != 6, rb);
      if (k < 5) chk(rb == rd_exp[k], "R5 read sequence", {24'd0, rb}, {24'd0, rd_exp[k]});
      else       chk(rb == rd_exp[k], "R6 past last reg", {24'd0, rb}, {24'd0, rd_exp[k]});
    end
    chk(sda_oe == 1'b0, "R7 released after nack", {31'd0, sda_oe}, 32'd0);
    bus_stop();

    // write past the end
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h06, 1'b0, ack);
    send_byte(8'h05, 1'b0, ack);
    send_byte(8'h06, 1'b0, ack);
    send_byte(8'h07, 1'b0, ack);
    send_byte(8'h08, 1'b0, ack);
    send_byte(8'h9A, 1'b0, ack);
    chk(ack, "R4 extra byte acked", {31'd0, ack}, 32'd1);
    send_byte(8'hBC, 1'b0, ack);
    chk(ack, "R4 extra byte acked", {31'd0, ack}, 32'd1);
    bus_stop();
    exp_r = 32'h0807_0605;
    chk(reg_q == exp_r, "R4 extra discarded", reg_q, exp_r);

    // repeated START resets the pointer
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    send_byte(8'hC3, 1'b0, ack);
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    chk(ack, "R8 address after restart", {31'd0, ack}, 32'd1);
    send_byte(8'h00, 1'b0, ack);
    send_byte(8'h01, 1'b0, ack);
    send_byte(8'h3C, 1'b0, ack);
    bus_stop();
    exp_r = 32'h0807_063C;
    chk(reg_q == exp_r, "R8 pointer reset", reg_q, exp_r);

    // NACK on the length byte ends the read
    bus_start();
    send_byte(8'hD3, 1'b0, ack);
    recv_byte(1'b0, rb);
    chk(rb == 8'h09, "R5 length byte", {24'd0, rb}, 32'h09);
    recv_byte(1'b0, rb);
    chk(rb == 8'hFF, "R7 no drive after nack", {24'd0, rb}, 32'hFF);
    bus_stop();

    // STOP returns to idle
    bus_start();
    send_byte(8'hD2, 1'b0, ack);
    send_byte(8'h00, 1'b0, ack);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released on stop", {31'd0, sda_oe}, 32'd0);
    m_scl = 1'b0;
    wq(1);
    send_byte(8'hD2, 1'b0, ack);
    chk(ack == 1'b0, "R9 idle after stop", {31'd0, ack}, 32'd0);
    bus_stop();

    // short pulses on both lines
    bus_start();
    send_byte(8'hD2, 1'b1, ack);
    chk(ack, "R10 glitched address", {31'd0, ack}, 32'd1);
    send_byte(8'h00, 1'b1, ack);
    send_byte(8'h01, 1'b1, ack);
    send_byte(8'h5A, 1'b1, ack);
    chk(ack, "R10 glitched data ack", {31'd0, ack}, 32'd1);
    bus_stop();
    exp_r = 32'h0807_065A;
    chk(reg_q == exp_r, "R10 glitch ignored", reg_q, exp_r);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule